// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a system bus address into one of eight active-low chip selects for an external expansion bus. It also forms the address presented on that bus. Each chip select owns a 5-bit size field. The field sets the byte size of that chip select's window as a power of two, between 512 bytes and 32 MB. An access that lands past the programmed window raises an error strobe and leaves every chip select inactive.

The block chooses between two layouts. In the narrow layout, each chip select owns a 16 MB slot. The eight slots fill 128 MB, and the next 128 MB repeats them. When any size field requests the 32 MB size, the wide layout applies to all chip selects. In that layout each chip select owns a 32 MB slot, and the eight slots fill 256 MB. Only bits 27:0 of the bus address are decoded; matching the higher bits against a base address is left to the bus fabric.

All outputs are registered. An address presented with its valid strobe is answered on the next clock edge, either with a hit and one chip select or with an error.

Top module: `exb_cs_decode`

## Requirements
- R1: The window exponent of chip select i is 9 + cfg[4:1] when bit 0 of its field is 0, and 25 when bit 0 is 1 (any higher bits are then ignored). An access hits when its offset within the slot is below 2^exponent. Examples: 00000 gives 512 B, 10000 gives 128 KB, 11110 gives 16 MB, 00001 gives 32 MB.
- R2: When no size field has bit 0 set, bus address bits 26:24 give the chip-select index, and `ext_addr` is bits 23:0 of the bus address with bit 24 at zero.
- R3: When any size field has bit 0 set, the wide layout applies to every chip select: bits 27:25 give the index, and bits 24:0 pass unchanged to `ext_addr`.
- R4: An access whose offset is at or above its window size produces `err`=1, `hit`=0, all of `cs_n` high and `ext_addr`=0 in the following cycle.
- R5: Bus address bits 31:28 do not affect the result. In the narrow layout bit 27 is also ignored, so the upper 128 MB repeats the lower 128 MB starting from chip select 0.
- R6: A cycle with `bus_valid` low yields `hit`=0, `err`=0, `cs_n` all high and `ext_addr`=0 in the following cycle.
- R7: Results appear exactly one clock after the address and valid are sampled. A valid access always yields exactly one of `hit` or `err`.
- R8: While `rst_n` is low, `cs_n` is all high and `hit`, `err` and `ext_addr` are 0.
- R9: At most one `cs_n` bit is low. On a hit, the low bit is the one at the decoded index (bit i low selects chip select i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | System bus byte address |
| bus_valid | input | 1 | Address qualifier |
| cs_cfg | input | 40 | Eight 5-bit size fields; chip select i at bits [5i+4:5i] |
| cs_n | output | 8 | Active-low chip selects |
| ext_addr | output | 25 | Expansion bus address |
| hit | output | 1 | Access fell inside a window |
| err | output | 1 | Access fell outside its window |

## Verification
The bench targets the last byte of each window and the byte just past it. A design with an off-by-one window limit would either drop a legal access to an error or select a device for an illegal one. It also sets bit 0 in a single field to flip the layout. A design that handled the layout per chip select would use the wrong index bits for the other seven, which shows up as the wrong chip select going low. Aliased addresses in the upper 128 MB and fields with bit 0 set plus other bits set catch index bits that are taken from the wrong place and exponents that are not clamped.

// File: rtl/exb_cs_pkg.sv
package exb_cs_pkg;
  localparam int unsigned CFG_W   = 5;
  localparam int unsigned MIN_EXP = 9;
  localparam int unsigned EXP_W   = 6;
  localparam int unsigned BIG_ADD = 16;

  // Window exponent from a size field, saturated at the slot width.
  function automatic logic [EXP_W-1:0] region_exp(input logic [CFG_W-1:0] cfg,
                                                  input int unsigned cap);
    int unsigned e;
    e = MIN_EXP + 32'(cfg[CFG_W-1:1]) + (cfg[0] ? BIG_ADD : 32'd0);
    if (e > cap) e = cap;
    return EXP_W'(e);
  endfunction

  // True when any offset bit at or above the exponent is set.
  function automatic logic beyond_window(input logic [31:0] ofs,
                                         input logic [EXP_W-1:0] e);
    return (ofs >> e) != 32'd0;
  endfunction
endpackage

// File: rtl/exb_size_unit.sv
module exb_size_unit
  import exb_cs_pkg::*;
#(
  parameter int unsigned CAP = 25
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [EXP_W-1:0] exp_out,
  output logic             wide_req
);
  assign exp_out  = region_exp(cfg, CAP);
  assign wide_req = cfg[0];
endmodule

// File: rtl/exb_slot_decode.sv
module exb_slot_decode
  import exb_cs_pkg::*;
#(
  parameter int unsigned NUM_CS   = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 24,
  parameter int unsigned WIDE_W   = 25,
  localparam int unsigned SEL_W   = $clog2(NUM_CS)
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wide_map,
  input  logic [NUM_CS*EXP_W-1:0] exp_vec,
  output logic [SEL_W-1:0]        sel_idx,
  output logic [WIDE_W-1:0]       slot_ofs,
  output logic [NUM_CS-1:0]       sel_onehot,
  output logic                    out_of_range
);
  logic [EXP_W-1:0] sel_exp;

  always_comb begin
    if (wide_map) begin
      sel_idx  = addr[WIDE_W +: SEL_W];
      slot_ofs = addr[WIDE_W-1:0];
    end else begin
      sel_idx  = addr[NARROW_W +: SEL_W];
      slot_ofs = {{(WIDE_W-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};
    end
  end

  assign sel_exp      = exp_vec[sel_idx*EXP_W +: EXP_W];
  assign out_of_range = beyond_window(32'(slot_ofs), sel_exp);

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
      assign sel_onehot[i] = (sel_idx == SEL_W'(i));
    end
  endgenerate
endmodule

// File: rtl/exb_cs_regs.sv
module exb_cs_regs #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned WIDE_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NUM_CS-1:0] sel_onehot,
  input  logic              out_of_range,
  input  logic [WIDE_W-1:0] slot_ofs,
  output logic [NUM_CS-1:0] cs_n,
  output logic [WIDE_W-1:0] ext_addr,
  output logic              hit,
  output logic              err
);
  logic take_hit, take_err;
  assign take_hit = req_valid && !out_of_range;
  assign take_err = req_valid &&  out_of_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n     <= '1;
      ext_addr <= '0;
      hit      <= 1'b0;
      err      <= 1'b0;
    end else begin
      cs_n     <= take_hit ? ~sel_onehot : '1;
      ext_addr <= take_hit ? slot_ofs : '0;
      hit      <= take_hit;
      err      <= take_err;
    end
  end

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n) && (hit == !(&cs_n)));
  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (&cs_n && !hit && ext_addr == '0));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (&cs_n && !hit && !err));
  // R7
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (hit != err));
endmodule

// File: rtl/exb_cs_decode.sv
module exb_cs_decode
  import exb_cs_pkg::*;
#(
  parameter int unsigned NUM_CS   = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 24,
  parameter int unsigned WIDE_W   = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_valid,
  input  logic [NUM_CS*CFG_W-1:0] cs_cfg,
  output logic [NUM_CS-1:0]       cs_n,
  output logic [WIDE_W-1:0]       ext_addr,
  output logic                    hit,
  output logic                    err
);
  localparam int unsigned SEL_W = $clog2(NUM_CS);

  logic [NUM_CS*EXP_W-1:0] exp_vec;
  logic [NUM_CS-1:0]       wide_req;
  logic                    wide_map;
  logic [SEL_W-1:0]        sel_idx;
  logic [WIDE_W-1:0]       slot_ofs;
  logic [NUM_CS-1:0]       sel_onehot;
  logic                    out_of_range;

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_size
      exb_size_unit #(.CAP(WIDE_W)) u_size (
        .cfg      (cs_cfg[i*CFG_W +: CFG_W]),
        .exp_out  (exp_vec[i*EXP_W +: EXP_W]),
        .wide_req (wide_req[i])
      );
    end
  endgenerate

  assign wide_map = |wide_req;

  exb_slot_decode #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
  ) u_dec (
    .addr         (bus_addr),
    .wide_map     (wide_map),
    .exp_vec      (exp_vec),
    .sel_idx      (sel_idx),
    .slot_ofs     (slot_ofs),
    .sel_onehot   (sel_onehot),
    .out_of_range (out_of_range)
  );

  exb_cs_regs #(.NUM_CS(NUM_CS), .WIDE_W(WIDE_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (bus_valid),
    .sel_onehot   (sel_onehot),
    .out_of_range (out_of_range),
    .slot_ofs     (slot_ofs),
    .cs_n         (cs_n),
    .ext_addr     (ext_addr),
    .hit          (hit),
    .err          (err)
  );

  // R3
  wide_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && wide_map && !out_of_range) |=> (ext_addr == $past(bus_addr[WIDE_W-1:0])));
  // R2
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !wide_map) |=> (ext_addr[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/exb_cs_decode_tb.sv
module exb_cs_decode_tb;
  localparam int NCS = 8;
  localparam int EW  = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   bus_addr = '0;
  logic          bus_valid = 1'b0;
  logic [39:0]   cs_cfg = '0;
  logic [7:0]    cs_n;
  logic [EW-1:0] ext_addr;
  logic          hit, err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  exb_cs_decode u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_valid(bus_valid),
    .cs_cfg(cs_cfg), .cs_n(cs_n), .ext_addr(ext_addr), .hit(hit), .err(err)
  );

  // Expected {cs_n, hit, err, ext_addr}, built from the size rule in bytes.
  function automatic logic [34:0] model(input logic [31:0] a, input logic v,
                                        input logic [39:0] cfgs);
    bit        wide = 0;
    int        idx;
    longint    off, size;
    logic [4:0] c;
    if (!v) return {8'hFF, 1'b0, 1'b0, 25'd0};
    for (int i = 0; i < NCS; i++) if (cfgs[i*5]) wide = 1;
    if (wide) begin idx = int'(a[27:25]); off = longint'(a[24:0]); end
    else      begin idx = int'(a[26:24]); off = longint'(a[23:0]); end
    c = cfgs[idx*5 +: 5];
    size = c[0] ? 64'h200_0000 : (64'd512 << c[4:1]);
    if (off < size)
      return {~(8'b1 << idx), 1'b1, 1'b0, 25'(off)};
    return {8'hFF, 1'b0, 1'b1, 25'd0};
  endfunction

  task automatic check(input string tag, input logic [34:0] exp_v);
    logic [34:0] act;
    act = {cs_n, hit, err, ext_addr};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got cs_n=%h hit=%b err=%b ext=%h, expected cs_n=%h hit=%b err=%b ext=%h",
               tag, act[34:27], act[26], act[25], act[24:0],
               exp_v[34:27], exp_v[26], exp_v[25], exp_v[24:0]);
    end
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic v);
    logic [34:0] e;
    @(negedge clk);
    bus_addr  = a;
    bus_valid = v;
    e = model(a, v, cs_cfg);
    @(negedge clk);
    check(tag, e);
  endtask

  task automatic set_cfg(input int idx, input logic [4:0] c);
    cs_cfg[idx*5 +: 5] = c;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    bus_addr  = 32'h0100_0000;
    bus_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset", {8'hFF, 1'b0, 1'b0, 25'd0});
    bus_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", {8'hFF, 1'b0, 1'b0, 25'd0});

    // Narrow layout directed cases
    set_cfg(1, 5'b10000);
    set_cfg(2, 5'b11110);
    access("R1 512B last byte",  32'h0000_01FF, 1'b1);
    access("R4 512B past end",   32'h0000_0200, 1'b1);
    access("R1 128KB last byte", 32'h0101_FFFF, 1'b1);
    access("R4 128KB past end",  32'h0102_0000, 1'b1);
    access("R1 16MB top",        32'h02FF_FFFF, 1'b1);
    access("R2 index bits",      32'h0200_1234, 1'b1);
    access("R5 alias upper 128M", 32'h0A00_0ABC, 1'b1);
    access("R5 bits 31:28",      32'hF000_0010, 1'b1);
    access("R6 valid low",       32'h0000_0010, 1'b0);
    access("R9 cs1 select",      32'h0100_0000, 1'b1);

    // Wide layout triggered by one field
    set_cfg(7, 5'b00001);
    access("R3 32MB last byte",  32'h0FFF_FFFF, 1'b1);
    access("R3 cs1 in wide",     32'h0200_0004, 1'b1);
    access("R4 wide 512B past",  32'h0000_0200, 1'b1);
    access("R3 no alias bit27",  32'h0800_0000, 1'b1);
    set_cfg(3, 5'b11111);
    access("R1 clamp 11111",     32'h07FF_FFFF, 1'b1);
    set_cfg(7, 5'b00000);
    access("R1 still wide",      32'h0600_0000, 1'b1);
    set_cfg(3, 5'b11110);
    access("R2 back narrow",     32'h0300_0001, 1'b1);

    // R7 back-to-back accesses
    access("R7 back to back a",  32'h0000_0000, 1'b1);
    access("R7 back to back b",  32'h0500_0000, 1'b1);

    // Random mix
    for (int blk = 0; blk < 40; blk++) begin
      for (int i = 0; i < NCS; i++) begin
        logic [4:0] c;
        c = 5'($urandom);
        if (blk % 2 == 0) c[0] = 1'b0;
        else if ($urandom_range(0, 3) != 0) c[0] = 1'b0;
        set_cfg(i, c);
      end
      for (int k = 0; k < 50; k++) begin
        logic [31:0] a;
        int sh;
        a  = $urandom;
        sh = $urandom_range(0, 25);
        a[24:0] = 25'($urandom) & 25'((64'd1 << sh) - 1);
        access("R1/R2/R3/R4/R5/R9 random", a, ($urandom_range(0, 7) != 0));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule